// File: doc/BRIEF.md
# PA Slot Sequencer

This block sequences an external power amplifier from a single receive-enable strobe. A low level on that strobe marks a transmit slot and a high level marks a receive slot. The strobe is first passed through a two-flop synchronizer, and all timing is taken from its synchronized edges.

A falling edge starts the transmit slot. The PA enable comes on only after a fixed delay in clocks. A loss of PLL lock or a low supply during the slot turns the PA off at once and keeps it off until the slot ends. A rising edge turns the PA off in the same cycle, fires a one-cycle PLL recalibration pulse after a short delay, and raises a receive-ready flag after a longer one.

The transmit-power-control bit from the register file reaches its open-drain output only at the start of a transmit slot. That output is modelled as an output-enable with constant-low data. All delays are parameters counted in system clocks. The defaults assume a 1.024 MHz tick, giving 64, 7 and 72 clocks.

Top module: `pa_slot_sequencer`

## Requirements
- R1: The PA enable rises exactly TX_ON_CLKS (default 64) clocks after the synchronized falling edge of receive-enable, when the slot is fault-free. With the two synchronizer flops, this is 66 rising clock edges after the input goes low.
- R2: The PA enable is low in the cycle in which the synchronized receive-enable rises, and it stays low for the whole receive slot.
- R3: If receive-enable rises before the turn-on delay expires, the PA enable does not assert at any point in that slot.
- R4: During a transmit slot, PLL lock low or the low-supply flag high drives the PA enable low in the same cycle. It stays low until the slot ends, even after the fault indication returns to normal.
- R5: The latched fault clears at the rising edge of receive-enable, so the next transmit slot turns the PA on normally.
- R6: Fault indications during a receive slot have no effect on the following transmit slot.
- R7: The recalibration output is a single-cycle pulse RECAL_CLKS (default 7) clocks after the synchronized rising edge, that is, 9 rising edges after the input goes high.
- R8: The receive-ready output is high from RX_RDY_CLKS (default 72) clocks after the synchronized rising edge until the next synchronized falling edge. It never asserts in a receive slot shorter than that.
- R9: The power-control output-enable (1 = pin pulled low, 0 = high impedance) takes the register bit's value only at a synchronized falling edge. Changes of the bit at other times do not affect it. The output data value is always 0.
- R10: After reset, the PA enable, recalibration, receive-ready and power-control output-enable are all 0.
- R11: Receive-enable passes through two synchronizer flops. No output reacts to an input change before the second rising clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (tick source) |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en_i | input | 1 | Receive-enable strobe, asynchronous; low = transmit slot |
| pll_lock_i | input | 1 | PLL lock-detect, high when locked |
| vlow_i | input | 1 | Low-supply indication, high when below threshold |
| pwr_bit_i | input | 1 | Transmit-power-control bit from the register file |
| pa_en_o | output | 1 | External PA enable |
| recal_o | output | 1 | One-cycle PLL recalibration pulse |
| rx_ready_o | output | 1 | Receive path ready |
| tpc_oe_o | output | 1 | Open-drain power-control output-enable |
| tpc_dat_o | output | 1 | Open-drain power-control data, constant 0 |

## Verification
Two functions can act in the same cycle: the delayed PA turn-on and the fault inhibit. The bench provokes this by pulsing the lock indication in exactly the cycle in which the turn-on count completes. The expected result is that the PA enable never goes high in that slot.

A second collision is between a power-control bit write and the slot edge. The bench changes the bit in mid-slot and expects the output to keep the value sampled at the falling edge. The faults injected during receive slots are judged by the next slot turning on at its normal cycle.

// File: rtl/pa_seq_pkg.sv
`timescale 1ns/1ps
package pa_seq_pkg;

  typedef enum logic {SLOT_RX = 1'b0, SLOT_TX = 1'b1} slot_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // counter width able to hold 0..n
  function automatic int unsigned ctr_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // whole ticks covering a time span, rounded up
  function automatic int unsigned ns_to_ticks(input int unsigned ns, input int unsigned tick_ps);
    return (ns * 1000 + tick_ps - 1) / tick_ps;
  endfunction

endpackage

// File: rtl/psq_rx_sync.sv
`timescale 1ns/1ps
module psq_rx_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic s1_q, s2_q, last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      last_q <= 1'b1;
    end else begin
      s1_q   <= d_i;
      s2_q   <= s1_q;
      last_q <= s2_q;
    end
  end

  assign lvl_o  = s2_q;
  assign rise_o = s2_q & ~last_q;
  assign fall_o = ~s2_q & last_q;

  // R11
  sync_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |-> $past(d_i, 2));
endmodule

// File: rtl/psq_delay_ctr.sv
`timescale 1ns/1ps
module psq_delay_ctr #(
  parameter int unsigned LIMIT = 64,
  parameter int unsigned TAP   = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic clr_i,
  output logic done_o,
  output logic tap_o
);
  import pa_seq_pkg::*;
  localparam int unsigned CW = ctr_width(max2(LIMIT, TAP));
  localparam logic [CW-1:0] LIM_V = CW'(LIMIT);
  localparam logic [CW-1:0] TAP_V = CW'(TAP);

  logic [CW-1:0] cnt_q;
  logic          running;

  assign running = (cnt_q != '0) && (cnt_q < LIM_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr_i)      cnt_q <= '0;
    else if (start_i)    cnt_q <= CW'(1);
    else if (running)    cnt_q <= cnt_q + CW'(1);
  end

  assign done_o = (cnt_q == LIM_V);
  assign tap_o  = (cnt_q == TAP_V);

  // R1
  ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !clr_i && !start_i) |=> (cnt_q == $past(cnt_q) + CW'(1)));
  // R3
  ctr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !done_o);
endmodule

// File: rtl/psq_fault_hold.sv
`timescale 1ns/1ps
module psq_fault_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic clr_i,
  input  logic fault_i,
  output logic held_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                held_o <= 1'b0;
    else if (clr_i)            held_o <= 1'b0;
    else if (arm_i && fault_i) held_o <= 1'b1;
  end

  // R4
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held_o && !clr_i) |=> held_o);
  // R6
  fault_rx_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!held_o && !arm_i) |=> !held_o);
endmodule

// File: rtl/pa_slot_sequencer.sv
`timescale 1ns/1ps
module pa_slot_sequencer #(
  parameter int unsigned TX_ON_CLKS  = 64,
  parameter int unsigned RECAL_CLKS  = 7,
  parameter int unsigned RX_RDY_CLKS = 72
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_en_i,
  input  logic pll_lock_i,
  input  logic vlow_i,
  input  logic pwr_bit_i,
  output logic pa_en_o,
  output logic recal_o,
  output logic rx_ready_o,
  output logic tpc_oe_o,
  output logic tpc_dat_o
);
  import pa_seq_pkg::*;

  logic  rx_lvl, rise_evt, fall_evt;
  slot_e slot;
  logic  tx_done, tx_tap_unused;
  logic  rx_done, recal_tap;
  logic  fault_now, fault_held;
  logic  pwr_q;

  psq_rx_sync u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(rx_en_i),
    .lvl_o(rx_lvl), .rise_o(rise_evt), .fall_o(fall_evt)
  );

  assign slot = rx_lvl ? SLOT_RX : SLOT_TX;

  psq_delay_ctr #(.LIMIT(TX_ON_CLKS), .TAP(TX_ON_CLKS)) u_tx_ctr (
    .clk(clk), .rst_n(rst_n), .start_i(fall_evt), .clr_i(rise_evt),
    .done_o(tx_done), .tap_o(tx_tap_unused)
  );

  psq_delay_ctr #(.LIMIT(RX_RDY_CLKS), .TAP(RECAL_CLKS)) u_rx_ctr (
    .clk(clk), .rst_n(rst_n), .start_i(rise_evt), .clr_i(fall_evt),
    .done_o(rx_done), .tap_o(recal_tap)
  );

  assign fault_now = ~pll_lock_i | vlow_i;

  psq_fault_hold u_fault (
    .clk(clk), .rst_n(rst_n), .arm_i(slot == SLOT_TX), .clr_i(rise_evt),
    .fault_i(fault_now), .held_o(fault_held)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pwr_q <= 1'b0;
    else if (fall_evt) pwr_q <= pwr_bit_i;
  end

  assign pa_en_o    = (slot == SLOT_TX) & tx_done & ~fault_held & ~fault_now;
  assign recal_o    = (slot == SLOT_RX) & recal_tap;
  assign rx_ready_o = (slot == SLOT_RX) & rx_done;
  assign tpc_oe_o   = pwr_q;
  assign tpc_dat_o  = 1'b0;

  // R2
  pa_off_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |-> !pa_en_o);
  // R4
  pa_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_held |-> !pa_en_o);
  // R7
  recal_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recal_o |=> !recal_o);
  // R8
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_ready_o && pa_en_o));
  // R9
  tpc_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tpc_oe_o) |-> $past(fall_evt));
endmodule

// File: tb/pa_slot_sequencer_test.sv
`timescale 1ns/1ps
module pa_slot_sequencer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b1, lock = 1'b1, vlow = 1'b0, pwr = 1'b0;
  logic pa_en, recal, rx_ready, tpc_oe, tpc_dat;
  int   n_chk = 0, n_bad = 0;
  bit   finished = 0;

  always #2 clk = ~clk;

  pa_slot_sequencer uut (
    .clk(clk), .rst_n(rst_n), .rx_en_i(rx_en), .pll_lock_i(lock),
    .vlow_i(vlow), .pwr_bit_i(pwr), .pa_en_o(pa_en), .recal_o(recal),
    .rx_ready_o(rx_ready), .tpc_oe_o(tpc_oe), .tpc_dat_o(tpc_dat)
  );

  // expected timing, from the requirements: 2 sync flops + delay
  localparam int PA_K    = 2 + 64;
  localparam int RECAL_K = 2 + 7;
  localparam int READY_K = 2 + 72;

  localparam int NV = 8;
  // per slot: tx length, fault cycle (0 none), fault kind (0 lock,1 supply), power bit, rx length
  localparam int TXL [NV] = '{80, 100, 90, 80, 40, 66, 65, 80};
  localparam int FAT [NV] = '{ 0,  30, 70,  0,  0,  0,  0, 66};
  localparam int FKD [NV] = '{ 0,   0,  1,  0,  0,  0,  0,  0};
  localparam int PWB [NV] = '{ 1,   0,  1,  1,  0,  1,  0,  0};
  localparam int RXL [NV] = '{90,  90, 90, 30, 90, 90, 90, 90};

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic prev_pwr;
    prev_pwr = 1'b0;
    // R10: reset state
    repeat (3) @(negedge clk);
    check("R10 pa_en", pa_en, 1'b0);
    check("R10 recal", recal, 1'b0);
    check("R10 rx_ready", rx_ready, 1'b0);
    check("R10 tpc_oe", tpc_oe, 1'b0);
    rst_n = 1'b1;
    repeat (5) begin
      @(negedge clk);
      check("R10 idle ready", rx_ready, 1'b0);
      check("R10 idle pa", pa_en, 1'b0);
    end

    for (int i = 0; i < NV; i++) begin
      // transmit slot
      rx_en = 1'b0;
      pwr   = PWB[i][0];
      for (int k = 1; k <= TXL[i]; k++) begin
        if (FAT[i] != 0 && k == FAT[i]) begin
          if (FKD[i] == 0) lock = 1'b0; else vlow = 1'b1;
        end else begin
          lock = 1'b1; vlow = 1'b0;
        end
        if (k == 20) pwr = ~PWB[i][0];
        @(posedge clk);
        @(negedge clk);
        if (k >= 2) begin
          // R1 R3 R4 R5: turn-on at PA_K unless a fault has occurred this slot
          check(FAT[i] != 0 ? "R4 pa_en" : (TXL[i] < PA_K ? "R3 pa_en" : "R1 pa_en"),
                pa_en, (k >= PA_K) && !(FAT[i] != 0 && k >= FAT[i]));
          check("R8 ready low in tx", rx_ready, 1'b0);
        end
        if (k == 1) check("R11 no early pa", pa_en, 1'b0);
        check("R9 tpc_oe", tpc_oe, (k >= 3) ? PWB[i][0] : prev_pwr);
      end
      check("R9 tpc_dat", tpc_dat, 1'b0);
      lock = 1'b1; vlow = 1'b0;
      prev_pwr = PWB[i][0];

      // receive slot
      rx_en = 1'b1;
      for (int k = 1; k <= RXL[i]; k++) begin
        vlow = (k == 5);   // R6: fault while receiving
        lock = !(k == 40);
        @(posedge clk);
        @(negedge clk);
        if (k >= 2) check("R2 pa_en off in rx", pa_en, 1'b0);
        check("R7 recal", recal, k == RECAL_K);
        if (k >= 2) check("R8 rx_ready", rx_ready, k >= READY_K);
        check("R9 tpc_oe hold", tpc_oe, PWB[i][0]);
      end
      vlow = 1'b0; lock = 1'b1;
    end

    // R5 R6: after a fault-latched slot and rx-slot faults, a clean slot turns on on time
    rx_en = 1'b0;
    repeat (PA_K - 1) @(posedge clk);
    @(negedge clk);
    check("R5 pa not yet", pa_en, 1'b0);
    @(posedge clk);
    @(negedge clk);
    check("R6 pa on time", pa_en, 1'b1);
    // R2: rise drops PA on the synchronized edge
    rx_en = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R11 pa held one clk", pa_en, 1'b1);
    @(posedge clk); @(negedge clk);
    check("R2 pa drop", pa_en, 1'b0);

    finished = 1;
    summary();
    $finish;
  end
endmodule